// File: doc/BRIEF.md
# Circular-Buffer Data Address Generator

This block forms data memory addresses for a DSP-style datapath. It keeps four 16-bit pointers, each with its own base and length for modulo addressing, and four 16-bit modify values. An 8-bit page value is placed above the selected pointer to form a 24-bit address. Each access command picks a pointer and a step. The step is either one of the modify registers or an 8-bit signed immediate. The command also says whether the address is taken before or after the step is applied.

A complete second copy of every register exists. A one-cycle strobe toggles which copy is live, so an interrupt handler can take over a clean register set without saving the interrupted context. Register writes and access commands always work on the live copy. The address appears one clock after the command, together with a valid flag.

Top module: `dag_top`

## Requirements
- R1: While rst_ni is low, addr_valid_o and addr_o are 0. Reset clears every pointer, modify, base, length and page register in both copies, so a post-modify access with step 0 on any pointer yields address 0.
- R2: A post-modify access (op_pre_i=0) outputs {page, pointer} and writes the stepped pointer back to that pointer.
- R3: A pre-modify access (op_pre_i=1) outputs {page, stepped pointer} and leaves the pointer unchanged.
- R4: With op_use_imm_i=1, the step is op_imm_i sign-extended from 8 bits, and the modify registers are not used.
- R5: Any of the four modify registers (op_mod_sel_i) can step any pointer (op_ptr_i).
- R6: With a nonzero length L and base B, a stepped pointer that reaches B+L or beyond has L subtracted. This applies to both pre- and post-modify.
- R7: With a nonzero length, a stepped pointer that falls below B has L added. The wrap is exact when the pointer is inside the window and the step magnitude is below L.
- R8: A length of 0 gives linear addressing. The stepped pointer wraps modulo 65536 and never carries into or borrows from the page bits.
- R9: addr_o[23:16] equals the live page register at the cycle of the command.
- R10: A one-cycle pulse on bank_swap_i toggles the live register copy, starting with the next cycle. The copy that is not live keeps its contents. The initial copy is live after reset.
- R11: Register writes use wr_kind_i encodings 0=pointer, 1=modify, 2=length, 3=base, 4=page, with wr_sel_i selecting the register (ignored for page). Encodings 5 to 7 are ignored. A pointer write in the same cycle as a post-modify of that pointer wins over the update.
- R12: addr_valid_o is high exactly in the cycle after a cycle with op_valid_i high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_valid_i | input | 1 | Access command present |
| op_ptr_i | input | 2 | Pointer select |
| op_pre_i | input | 1 | 1 = pre-modify, 0 = post-modify |
| op_use_imm_i | input | 1 | 1 = step by immediate |
| op_mod_sel_i | input | 2 | Modify register select |
| op_imm_i | input | 8 | Signed immediate step |
| wr_en_i | input | 1 | Register write strobe |
| wr_kind_i | input | 3 | Register kind to write |
| wr_sel_i | input | 2 | Register index to write |
| wr_data_i | input | 16 | Write data (page uses low 8 bits) |
| bank_swap_i | input | 1 | Toggle live register copy |
| addr_valid_o | output | 1 | addr_o holds a new address |
| addr_o | output | 24 | Page and offset address |

## Verification
The bench goes after window edges in both directions. A design that compares against B+L-1 or wraps only on positive steps leaves a pointer outside its buffer, and the bench sees this when it reads the pointer back. It also checks linear rollover past 0xFFFF and below 0, where a leak into the page field changes the upper address byte. Bank swaps are checked both ways: a design that shares one copy, or that clears the idle copy, returns the wrong pointer after swapping back. A same-cycle pointer write and post-modify shows whether the write wins. A pre-modify followed by a read-back exposes a design that updates the pointer on pre-modify.

// File: rtl/dag_pkg.sv
package dag_pkg;
  localparam int unsigned NUM_BANKS = 2;

  typedef enum logic [2:0] {
    WR_IDX  = 3'd0,
    WR_MOD  = 3'd1,
    WR_LEN  = 3'd2,
    WR_BASE = 3'd3,
    WR_PAGE = 3'd4
  } wr_kind_e;
endpackage

// File: rtl/dag_modulo.sv
module dag_modulo #(
  parameter int unsigned IDX_W = 16
) (
  input  logic [IDX_W-1:0] idx_i,
  input  logic [IDX_W-1:0] delta_i,
  input  logic [IDX_W-1:0] base_i,
  input  logic [IDX_W-1:0] len_i,
  output logic [IDX_W-1:0] nxt_o
);
  localparam int unsigned EW = IDX_W + 2;

  logic [EW-1:0] sum, lo, hi, dn, up;

  always_comb begin
    sum = {2'b00, idx_i} + {{2{delta_i[IDX_W-1]}}, delta_i};
    lo  = {2'b00, base_i};
    hi  = {2'b00, base_i} + {2'b00, len_i};
    dn  = sum - {2'b00, len_i};
    up  = sum + {2'b00, len_i};
    if (len_i == '0)                    nxt_o = sum[IDX_W-1:0];
    else if ($signed(sum) >= $signed(hi)) nxt_o = dn[IDX_W-1:0];
    else if ($signed(sum) < $signed(lo))  nxt_o = up[IDX_W-1:0];
    else                                nxt_o = sum[IDX_W-1:0];
  end
endmodule

// File: rtl/dag_bank.sv
module dag_bank
  import dag_pkg::*;
#(
  parameter int unsigned IDX_W  = 16,
  parameter int unsigned PAGE_W = 8,
  parameter int unsigned N_PTR  = 4,
  parameter int unsigned SEL_W  = 2
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         wr_en_i,
  input  logic [2:0]                   wr_kind_i,
  input  logic [SEL_W-1:0]             wr_sel_i,
  input  logic [IDX_W-1:0]             wr_data_i,
  input  logic                         upd_en_i,
  input  logic [SEL_W-1:0]             upd_sel_i,
  input  logic [IDX_W-1:0]             upd_val_i,
  output logic [N_PTR-1:0][IDX_W-1:0]  idx_o,
  output logic [N_PTR-1:0][IDX_W-1:0]  mod_o,
  output logic [N_PTR-1:0][IDX_W-1:0]  len_o,
  output logic [N_PTR-1:0][IDX_W-1:0]  base_o,
  output logic [PAGE_W-1:0]            page_o
);
  for (genvar p = 0; p < N_PTR; p++) begin : g_reg
    logic hit;
    assign hit = wr_en_i && (wr_sel_i == SEL_W'(p));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        idx_o[p]  <= '0;
        mod_o[p]  <= '0;
        len_o[p]  <= '0;
        base_o[p] <= '0;
      end else begin
        // explicit write has priority over a post-modify update
        if (hit && wr_kind_i == WR_IDX)                 idx_o[p] <= wr_data_i;
        else if (upd_en_i && upd_sel_i == SEL_W'(p))    idx_o[p] <= upd_val_i;
        if (hit && wr_kind_i == WR_MOD)  mod_o[p]  <= wr_data_i;
        if (hit && wr_kind_i == WR_LEN)  len_o[p]  <= wr_data_i;
        if (hit && wr_kind_i == WR_BASE) base_o[p] <= wr_data_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             page_o <= '0;
    else if (wr_en_i && wr_kind_i == WR_PAGE) page_o <= wr_data_i[PAGE_W-1:0];
  end
endmodule

// File: rtl/dag_top.sv
module dag_top
  import dag_pkg::*;
#(
  parameter int unsigned IDX_W  = 16,
  parameter int unsigned PAGE_W = 8,
  parameter int unsigned N_PTR  = 4,
  parameter int unsigned IMM_W  = 8,
  localparam int unsigned SEL_W  = $clog2(N_PTR),
  localparam int unsigned ADDR_W = PAGE_W + IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              op_valid_i,
  input  logic [SEL_W-1:0]  op_ptr_i,
  input  logic              op_pre_i,
  input  logic              op_use_imm_i,
  input  logic [SEL_W-1:0]  op_mod_sel_i,
  input  logic [IMM_W-1:0]  op_imm_i,
  input  logic              wr_en_i,
  input  logic [2:0]        wr_kind_i,
  input  logic [SEL_W-1:0]  wr_sel_i,
  input  logic [IDX_W-1:0]  wr_data_i,
  input  logic              bank_swap_i,
  output logic              addr_valid_o,
  output logic [ADDR_W-1:0] addr_o
);
  logic                        act_q;
  logic [N_PTR-1:0][IDX_W-1:0] bk_idx  [NUM_BANKS];
  logic [N_PTR-1:0][IDX_W-1:0] bk_mod  [NUM_BANKS];
  logic [N_PTR-1:0][IDX_W-1:0] bk_len  [NUM_BANKS];
  logic [N_PTR-1:0][IDX_W-1:0] bk_base [NUM_BANKS];
  logic [PAGE_W-1:0]           bk_page [NUM_BANKS];

  logic [N_PTR-1:0][IDX_W-1:0] idx_act;
  logic [IDX_W-1:0] cur_idx, cur_base, cur_len, delta, nxt_idx;
  logic [PAGE_W-1:0] cur_page;
  logic upd_en;

  assign upd_en = op_valid_i && !op_pre_i;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    dag_bank #(
      .IDX_W(IDX_W), .PAGE_W(PAGE_W), .N_PTR(N_PTR), .SEL_W(SEL_W)
    ) u_bank (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_en_i   (wr_en_i && (act_q == 1'(b))),
      .wr_kind_i (wr_kind_i),
      .wr_sel_i  (wr_sel_i),
      .wr_data_i (wr_data_i),
      .upd_en_i  (upd_en && (act_q == 1'(b))),
      .upd_sel_i (op_ptr_i),
      .upd_val_i (nxt_idx),
      .idx_o     (bk_idx[b]),
      .mod_o     (bk_mod[b]),
      .len_o     (bk_len[b]),
      .base_o    (bk_base[b]),
      .page_o    (bk_page[b])
    );
  end

  always_comb begin
    idx_act  = bk_idx[act_q];
    cur_idx  = idx_act[op_ptr_i];
    cur_base = bk_base[act_q][op_ptr_i];
    cur_len  = bk_len[act_q][op_ptr_i];
    cur_page = bk_page[act_q];
    delta    = op_use_imm_i ? {{(IDX_W-IMM_W){op_imm_i[IMM_W-1]}}, op_imm_i}
                            : bk_mod[act_q][op_mod_sel_i];
  end

  dag_modulo #(.IDX_W(IDX_W)) u_modulo (
    .idx_i   (cur_idx),
    .delta_i (delta),
    .base_i  (cur_base),
    .len_i   (cur_len),
    .nxt_o   (nxt_idx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q        <= 1'b0;
      addr_valid_o <= 1'b0;
      addr_o       <= '0;
    end else begin
      act_q        <= act_q ^ bank_swap_i;
      addr_valid_o <= op_valid_i;
      if (op_valid_i) addr_o <= {cur_page, op_pre_i ? nxt_idx : cur_idx};
    end
  end

  // checking helpers
  logic [IDX_W:0]   win_hi;
  logic [IDX_W-1:0] delta_mag;
  logic             in_win, small_step;
  assign win_hi     = {1'b0, cur_base} + {1'b0, cur_len};
  assign delta_mag  = delta[IDX_W-1] ? (~delta + 1'b1) : delta;
  assign in_win     = (cur_len != '0) && (cur_idx >= cur_base) && ({1'b0, cur_idx} < win_hi);
  assign small_step = delta_mag < cur_len;

  assert_valid_follows_op_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_i |=> addr_valid_o);
  assert_no_valid_without_op_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !op_valid_i |=> !addr_valid_o);
  assert_page_on_top_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_i |=> addr_o[ADDR_W-1:IDX_W] == $past(cur_page));
  assert_stays_in_window_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && in_win && small_step) |->
      (nxt_idx >= cur_base) && ({1'b0, nxt_idx} < win_hi));
  assert_pre_keeps_index_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && op_pre_i && !bank_swap_i && !(wr_en_i && wr_kind_i == WR_IDX)) |=>
      idx_act[$past(op_ptr_i)] == $past(cur_idx));
  assert_write_wins_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_kind_i == WR_IDX && !bank_swap_i) |=>
      idx_act[$past(wr_sel_i)] == $past(wr_data_i));
endmodule

// File: tb/test_dag_top.sv
module test_dag_top;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        op_valid_i = 1'b0;
  logic [1:0]  op_ptr_i = '0;
  logic        op_pre_i = 1'b0;
  logic        op_use_imm_i = 1'b0;
  logic [1:0]  op_mod_sel_i = '0;
  logic [7:0]  op_imm_i = '0;
  logic        wr_en_i = 1'b0;
  logic [2:0]  wr_kind_i = '0;
  logic [1:0]  wr_sel_i = '0;
  logic [15:0] wr_data_i = '0;
  logic        bank_swap_i = 1'b0;
  logic        addr_valid_o;
  logic [23:0] addr_o;

  int   n_run = 0;
  int   n_fail = 0;
  bit   done = 1'b0;
  logic [23:0] exp_q[$];
  string       req_q[$];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  dag_top i_dag_top (
    .clk_i, .rst_ni, .op_valid_i, .op_ptr_i, .op_pre_i, .op_use_imm_i,
    .op_mod_sel_i, .op_imm_i, .wr_en_i, .wr_kind_i, .wr_sel_i, .wr_data_i,
    .bank_swap_i, .addr_valid_o, .addr_o
  );

  task automatic check(bit ok, string req, logic [23:0] act, logic [23:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %06h expected %06h", req, act, exp);
    end
  endtask

  // monitor: pops scoreboard on every valid address
  always @(negedge clk_i) begin
    if (rst_ni && addr_valid_o) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R12 unexpected valid", addr_o, 24'h0);
      end else begin
        logic [23:0] e;
        string r;
        e = exp_q.pop_front();
        r = req_q.pop_front();
        check(addr_o == e, r, addr_o, e);
      end
    end
  end

  task automatic wr(input int kind, input int sel, input logic [15:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_kind_i = 3'(kind); wr_sel_i = 2'(sel); wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic op(input int ptr, input bit pre, input bit use_imm, input int msel,
                    input logic [7:0] imm, input logic [23:0] exp, input string req);
    @(negedge clk_i);
    op_valid_i = 1'b1; op_ptr_i = 2'(ptr); op_pre_i = pre; op_use_imm_i = use_imm;
    op_mod_sel_i = 2'(msel); op_imm_i = imm;
    exp_q.push_back(exp); req_q.push_back(req);
    @(negedge clk_i);
    op_valid_i = 1'b0;
  endtask

  task automatic peek(input int ptr, input logic [23:0] exp, input string req);
    op(ptr, 1'b0, 1'b1, 0, 8'h00, exp, req);
  endtask

  task automatic swap();
    @(negedge clk_i);
    bank_swap_i = 1'b1;
    @(negedge clk_i);
    bank_swap_i = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    check(addr_valid_o == 1'b0 && addr_o == 24'h0, "R1 reset outputs", addr_o, 24'h0);
    rst_ni = 1'b1;
    peek(1, 24'h000000, "R1 cleared regs");

    // R9 page, R2 post-modify
    wr(4, 0, 16'h005A);
    wr(0, 0, 16'h1000);
    wr(1, 1, 16'h0010);
    op(0, 1'b0, 1'b0, 1, 8'h00, 24'h5A1000, "R2 post output");
    peek(0, 24'h5A1010, "R2 post update");
    // R3 pre-modify
    op(0, 1'b1, 1'b0, 1, 8'h00, 24'h5A1020, "R3 pre output");
    peek(0, 24'h5A1010, "R3 pre no update");
    // R4 immediates
    op(0, 1'b0, 1'b1, 1, 8'hFD, 24'h5A1010, "R4 imm post output");
    peek(0, 24'h5A100D, "R4 imm negative update");
    op(0, 1'b1, 1'b1, 1, 8'h7F, 24'h5A108C, "R4 imm positive pre");
    peek(0, 24'h5A100D, "R4 pre imm no update");
    // R5 any modify with any pointer
    wr(0, 2, 16'h0200);
    wr(1, 3, 16'hFFF0);
    op(2, 1'b0, 1'b0, 3, 8'h00, 24'h5A0200, "R5 ptr2 mod3 output");
    peek(2, 24'h5A01F0, "R5 ptr2 mod3 update");
    wr(1, 0, 16'h0001);
    wr(0, 3, 16'h0300);
    op(3, 1'b1, 1'b0, 0, 8'h00, 24'h5A0301, "R5 ptr3 mod0 pre");
    // R6 upward wrap, window 0x100..0x107
    wr(0, 1, 16'h0105);
    wr(3, 1, 16'h0100);
    wr(2, 1, 16'h0008);
    wr(1, 2, 16'h0003);
    op(1, 1'b0, 1'b0, 2, 8'h00, 24'h5A0105, "R6 post output");
    peek(1, 24'h5A0100, "R6 wrap at top");
    op(1, 1'b0, 1'b0, 2, 8'h00, 24'h5A0100, "R6 post at base");
    peek(1, 24'h5A0103, "R6 no wrap inside");
    op(1, 1'b1, 1'b1, 0, 8'h05, 24'h5A0100, "R6 pre wraps");
    // R7 downward wrap
    op(1, 1'b0, 1'b1, 0, 8'hFB, 24'h5A0103, "R7 post output");
    peek(1, 24'h5A0106, "R7 wrap below base");
    // R8 linear rollover
    wr(0, 2, 16'hFFFE);
    op(2, 1'b0, 1'b1, 0, 8'h04, 24'h5AFFFE, "R8 post output");
    peek(2, 24'h5A0002, "R8 rollover up no page carry");
    wr(0, 3, 16'h0001);
    op(3, 1'b0, 1'b1, 0, 8'hFE, 24'h5A0001, "R8 post output neg");
    peek(3, 24'h5AFFFF, "R8 rollover down no page borrow");
    // R10 bank swap
    swap();
    peek(0, 24'h000000, "R10 second copy clear");
    wr(4, 0, 16'h0033);
    wr(0, 0, 16'h0040);
    peek(0, 24'h330040, "R10 write to live copy");
    swap();
    peek(0, 24'h5A100D, "R10 first copy kept");
    swap();
    peek(0, 24'h330040, "R10 second copy kept");
    swap();
    // R11 write wins, ignored kind
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_kind_i = 3'd0; wr_sel_i = 2'd0; wr_data_i = 16'h2222;
    op_valid_i = 1'b1; op_ptr_i = 2'd0; op_pre_i = 1'b0; op_use_imm_i = 1'b1; op_imm_i = 8'h01;
    exp_q.push_back(24'h5A100D); req_q.push_back("R11 old address");
    @(negedge clk_i);
    wr_en_i = 1'b0; op_valid_i = 1'b0;
    peek(0, 24'h5A2222, "R11 write wins");
    wr(7, 0, 16'h0099);
    peek(0, 24'h5A2222, "R11 unused kind ignored");
    // R12 idle cycles
    repeat (3) @(negedge clk_i);
    check(addr_valid_o == 1'b0, "R12 idle valid low", {23'h0, addr_valid_o}, 24'h0);
    check(exp_q.size() == 0, "R12 all results seen", 24'(exp_q.size()), 24'h0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      check(1'b0, "watchdog", 24'h0, 24'h0);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule